// File: doc/BRIEF.md
# ADC Queue Scan Trigger Sequencer

This block walks a short list of conversion command words held in a local command store. It asks an external converter for one conversion per word and waits for the converter's done pulse before moving on. Each word names an input channel and carries two flags. One flag holds the scan until the next trigger. The other flag marks the last word of the queue. The converter itself and the result storage sit outside the block.

Software picks one of three single-scan trigger sources with `mode` and then arms the queue with a one-cycle `arm` pulse. In software mode the scan begins at once, and each pause resumes by itself after one visible cycle. In edge mode the scan begins on a chosen edge of `ext_trig`, and each pause waits for another such edge. In timer mode an interval counter of 2^(7+`tmr_sel`) conversion-clock ticks starts when the queue is armed. Each expiry of this counter starts the queue or resumes it from a pause. When the scan finishes, the block drops the armed flag by itself. A hardware trigger that arrives while a conversion is running sets a sticky overrun flag.

Top module: `adc_queue_sequencer`

## Requirements
- R1: After reset, `scan_armed`, `scan_active`, `scan_paused`, `trig_overrun` and `conv_req` are all 0.
- R2: A command word is written with `ccw_we` at `ccw_addr`. Its bits [3:0] hold the channel, bit 4 is the pause flag and bit 5 is the end flag. A scan issues words strictly in order from address 0. `conv_chan` carries the word's channel, and `conv_req` stays high with a stable channel until `conv_done`. Only one request is outstanding at a time.
- R3: `mode`=0 is software mode. An `arm` pulse, driven at a falling edge, makes `conv_req` visible at the second following falling edge.
- R4: In software mode, finishing a word that has the pause flag and not the end flag makes `scan_paused` high for exactly one cycle. The scan then resumes with the next word.
- R5: In software mode `trig_overrun` is never set, whatever `ext_trig` does.
- R6: `mode`=1 is edge mode. `edge_rise`=1 selects rising edges of `ext_trig` and 0 selects falling edges. An edge of the other polarity, or any edge while the queue is not armed, has no effect. A qualifying edge starts the scan, with `conv_req` visible one cycle later.
- R7: A scan ends after the word that has the end flag, or after the word at the last address, whichever comes first. `scan_armed` then drops and no further request is made until the next `arm`.
- R8: `mode`=2 is timer mode. The first request follows the registered `arm` by 2^(7+`tmr_sel`) ticks of `qclk_en`.
- R9: In edge or timer mode, a paused scan stays paused, with `conv_req` low, until the next qualifying trigger.
- R10: An `ext_trig` edge of the selected polarity in edge mode, or a timer expiry in timer mode, that arrives while a conversion is in progress sets `trig_overrun`. The flag stays set until an `ovr_clr` pulse, and the trigger does not change the scan.
- R11: The interval timer is held at zero while the queue is not armed, so every new arm waits a full period.
- R12: An `arm` pulse while the queue is armed is ignored, and a `conv_done` with no request outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Trigger source: 0 software, 1 edge, 2 timer, 3 off |
| edge_rise | input | 1 | Edge polarity for edge mode (1 rising, 0 falling) |
| tmr_sel | input | 4 | Timer exponent offset, period 2^(7+tmr_sel) ticks, values above 10 give 2^17 |
| qclk_en | input | 1 | Conversion-clock tick enable for the interval timer |
| ext_trig | input | 1 | External trigger level, synchronous to clk |
| arm | input | 1 | One-cycle pulse that sets the single-scan enable |
| ovr_clr | input | 1 | One-cycle pulse that clears the overrun flag |
| ccw_we | input | 1 | Command word write strobe |
| ccw_addr | input | 3 | Command word write address |
| ccw_wdata | input | 6 | Command word: channel [3:0], pause [4], end [5] |
| conv_req | output | 1 | Conversion request, held until done |
| conv_chan | output | 4 | Channel of the current request |
| conv_done | input | 1 | Converter completion pulse |
| scan_armed | output | 1 | Single-scan enable state |
| scan_active | output | 1 | A conversion is in progress |
| scan_paused | output | 1 | Scan held at a pause |
| trig_overrun | output | 1 | Sticky trigger overrun flag |

## Verification
The assertions assume that `mode`, `tmr_sel` and the command store stay constant while a scan is armed. They also assume that `conv_done` comes only as a single pulse. The stimulus programs the store and the configuration only while the block is idle. A converter model in the bench answers each request with one `conv_done` pulse after a random or fixed latency. External edges are placed either while the scan waits or paused, or deliberately inside a long conversion for the overrun cases. During software-mode runs `ext_trig` toggles at random to show that it is ignored.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

  typedef enum logic [1:0] {
    MODE_SW  = 2'd0,
    MODE_EXT = 2'd1,
    MODE_TMR = 2'd2,
    MODE_OFF = 2'd3
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_e;

endpackage

// File: rtl/adcq_cmd_store.sv
module adcq_cmd_store #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 6,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic              hit;
    logic [WORD_W-1:0] word_q;

    assign hit = wr_en && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (hit) begin
        word_q <= wr_data;
      end
    end

    assign words[g] = word_q;
  end

  assign rd_data = words[rd_addr];

endmodule

// File: rtl/adcq_trig.sv
module adcq_trig #(
  parameter int TMR_MIN = 7,
  parameter int TMR_MAX = 17,
  parameter int SEL_W   = 4,
  localparam int CNT_W   = TMR_MAX,
  localparam int EXP_W   = $clog2(TMR_MAX + 1),
  localparam int SEL_MAX = TMR_MAX - TMR_MIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_tmr,
  input  logic             qclk_en,
  input  logic [SEL_W-1:0] tmr_sel,
  input  logic             ext_in,
  input  logic             edge_rise,
  output logic             ext_edge,
  output logic             tmr_fire
);

  logic             ext_q, ext_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXP_W-1:0] exp_n;
  logic [CNT_W-1:0] period_m1;
  logic             at_end;

  // period exponent, clamped to the top of the range
  always_comb begin
    if (tmr_sel > SEL_W'(SEL_MAX)) begin
      exp_n = EXP_W'(TMR_MAX);
    end else begin
      exp_n = EXP_W'(TMR_MIN) + EXP_W'(tmr_sel);
    end
    period_m1 = (CNT_W'(1) << exp_n) - CNT_W'(1);
  end

  assign at_end   = (cnt_q >= period_m1);
  assign tmr_fire = run_tmr && qclk_en && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_tmr) begin
      cnt_d = '0;
    end else if (qclk_en) begin
      cnt_d = at_end ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign ext_d    = ext_in;
  assign ext_edge = edge_rise ? (ext_in && !ext_q) : (!ext_in && ext_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ext_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ext_q <= ext_d;
    end
  end

  // R11: the counter sits at zero whenever the queue is not armed for the timer
  a_r11_timer_held: assert property (@(posedge clk) disable iff (!rst_n)
    !run_tmr |=> (cnt_q == '0));

  // R8: every expiry reloads the counter
  a_r8_fire_reload: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_fire |=> (cnt_q == '0));

endmodule

// File: rtl/adcq_ctrl.sv
module adcq_ctrl
  import adcq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scan_mode_e        mode,
  input  logic              arm,
  input  logic              ovr_clr,
  input  logic              ext_edge,
  input  logic              tmr_fire,
  input  logic              conv_done,
  input  logic              ccw_pause,
  input  logic              ccw_eoq,
  output logic [ADDR_W-1:0] ptr,
  output logic              conv_req,
  output logic              sse,
  output logic              paused,
  output logic              ovr,
  output logic              run_tmr
);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              sse_q, sse_d;
  logic              ovr_q, ovr_d;
  logic              hw_trig, trig, end_hit;

  assign hw_trig = ((mode == MODE_EXT) && ext_edge) ||
                   ((mode == MODE_TMR) && tmr_fire);
  assign trig    = (mode == MODE_SW) || hw_trig;
  assign end_hit = ccw_eoq || (ptr_q == ADDR_W'(DEPTH - 1));

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    sse_d   = sse_q;
    ovr_d   = ovr_q;
    case (state_q)
      ST_IDLE: begin
        if (arm && (mode != MODE_OFF)) begin
          sse_d   = 1'b1;
          ptr_d   = '0;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT, ST_HOLD: begin
        if (trig) begin
          state_d = ST_CONV;
        end
      end
      ST_CONV: begin
        if (conv_done) begin
          if (end_hit) begin
            sse_d   = 1'b0;
            state_d = ST_IDLE;
          end else begin
            ptr_d = ptr_q + ADDR_W'(1);
            if (ccw_pause) begin
              state_d = ST_HOLD;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (ovr_clr) begin
      ovr_d = 1'b0;
    end
    if ((state_q == ST_CONV) && hw_trig) begin
      ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      sse_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      sse_q   <= sse_d;
      ovr_q   <= ovr_d;
    end
  end

  assign ptr      = ptr_q;
  assign conv_req = (state_q == ST_CONV);
  assign paused   = (state_q == ST_HOLD);
  assign sse      = sse_q;
  assign ovr      = ovr_q;
  assign run_tmr  = sse_q && (mode == MODE_TMR);

  // R2: a request is held on the same word until the converter answers
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> (conv_req && $stable(ptr_q)));

  // R4: a software-mode pause lasts a single cycle
  a_r4_sw_pause_short: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && (mode == MODE_SW)) |=> conv_req);

  // R5: software mode never raises the overrun flag
  a_r5_sw_no_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_SW) && !ovr_q) |=> !ovr_q);

  // R7: the last word disarms the queue
  a_r7_end_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done && end_hit) |=> (!sse_q && !conv_req));

  // R10: overrun is sticky until cleared
  a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr) |=> ovr_q);

  // R12: a second arm while armed does not restart or drop the scan
  a_r12_rearm_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sse_q && arm && !conv_done) |=> (sse_q && $stable(ptr_q)));

endmodule

// File: rtl/adc_queue_sequencer.sv
module adc_queue_sequencer
  import adcq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int CHAN_W  = 4,
  parameter int TMR_MIN = 7,
  parameter int TMR_MAX = 17,
  parameter int SEL_W   = 4,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = CHAN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              edge_rise,
  input  logic [SEL_W-1:0]  tmr_sel,
  input  logic              qclk_en,
  input  logic              ext_trig,
  input  logic              arm,
  input  logic              ovr_clr,
  input  logic              ccw_we,
  input  logic [ADDR_W-1:0] ccw_addr,
  input  logic [WORD_W-1:0] ccw_wdata,
  output logic              conv_req,
  output logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_done,
  output logic              scan_armed,
  output logic              scan_active,
  output logic              scan_paused,
  output logic              trig_overrun
);

  scan_mode_e        mode_e;
  logic [ADDR_W-1:0] rd_ptr;
  logic [WORD_W-1:0] cur_word;
  logic              ext_edge, tmr_fire, run_tmr;

  assign mode_e = scan_mode_e'(mode);

  adcq_cmd_store #(
    .DEPTH  (DEPTH),
    .WORD_W (WORD_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ccw_we),
    .wr_addr (ccw_addr),
    .wr_data (ccw_wdata),
    .rd_addr (rd_ptr),
    .rd_data (cur_word)
  );

  adcq_trig #(
    .TMR_MIN (TMR_MIN),
    .TMR_MAX (TMR_MAX),
    .SEL_W   (SEL_W)
  ) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_tmr   (run_tmr),
    .qclk_en   (qclk_en),
    .tmr_sel   (tmr_sel),
    .ext_in    (ext_trig),
    .edge_rise (edge_rise),
    .ext_edge  (ext_edge),
    .tmr_fire  (tmr_fire)
  );

  adcq_ctrl #(
    .DEPTH (DEPTH)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_e),
    .arm       (arm),
    .ovr_clr   (ovr_clr),
    .ext_edge  (ext_edge),
    .tmr_fire  (tmr_fire),
    .conv_done (conv_done),
    .ccw_pause (cur_word[CHAN_W]),
    .ccw_eoq   (cur_word[CHAN_W+1]),
    .ptr       (rd_ptr),
    .conv_req  (conv_req),
    .sse       (scan_armed),
    .paused    (scan_paused),
    .ovr       (trig_overrun),
    .run_tmr   (run_tmr)
  );

  assign conv_chan   = cur_word[CHAN_W-1:0];
  assign scan_active = conv_req;

  // R1: nothing is requested while the queue is disarmed
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_armed |-> (!conv_req && !scan_paused));

endmodule

// File: tb/adc_queue_sequencer_test.sv
module adc_queue_sequencer_test;

  localparam int DEPTH = 8;

  logic       clk, rst_n;
  logic [1:0] mode;
  logic       edge_rise, qclk_en, ext_trig, arm, ovr_clr, ccw_we;
  logic [3:0] tmr_sel;
  logic [2:0] ccw_addr;
  logic [5:0] ccw_wdata;
  logic       conv_req, conv_done, cvt_done, spur_done;
  logic [3:0] conv_chan;
  logic       scan_armed, scan_active, scan_paused, trig_overrun;

  int n_chk, n_fail;
  int log_chan [64];
  int log_n, pause_cnt, lat_fix;
  bit sw_noise;
  logic [3:0] m_chan [DEPTH];
  bit m_pause [DEPTH];
  bit m_eoq [DEPTH];

  assign conv_done = cvt_done | spur_done;

  adc_queue_sequencer uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .edge_rise(edge_rise),
    .tmr_sel(tmr_sel), .qclk_en(qclk_en), .ext_trig(ext_trig), .arm(arm),
    .ovr_clr(ovr_clr), .ccw_we(ccw_we), .ccw_addr(ccw_addr),
    .ccw_wdata(ccw_wdata), .conv_req(conv_req), .conv_chan(conv_chan),
    .conv_done(conv_done), .scan_armed(scan_armed), .scan_active(scan_active),
    .scan_paused(scan_paused), .trig_overrun(trig_overrun));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  // converter model
  initial begin
    cvt_done = 1'b0;
    forever begin
      @(negedge clk);
      cvt_done = 1'b0;
      if (conv_req) begin
        log_chan[log_n % 64] = int'(conv_chan);
        log_n++;
        repeat ((lat_fix >= 0) ? lat_fix : int'($urandom_range(0, 3))) @(negedge clk);
        cvt_done = 1'b1;
      end
    end
  end

  // pause and noise monitor
  initial begin
    forever begin
      @(negedge clk);
      if (scan_paused) pause_cnt++;
      if (sw_noise) ext_trig = 1'($urandom);
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input int ch, input bit p, input bit e);
    m_chan[a] = 4'(ch); m_pause[a] = p; m_eoq[a] = e;
    @(negedge clk);
    ccw_we = 1'b1; ccw_addr = 3'(a); ccw_wdata = {e, p, 4'(ch)};
    @(negedge clk);
    ccw_we = 1'b0;
  endtask

  task automatic fill_end();
    for (int i = 0; i < DEPTH; i++) put(i, i, 1'b0, 1'b1);
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (scan_armed && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic wait_paused();
    int t = 0;
    while (!scan_paused && t < 3000) begin @(negedge clk); t++; end
  endtask

  function automatic int exp_len();
    for (int i = 0; i < DEPTH; i++) if (m_eoq[i] || i == DEPTH - 1) return i + 1;
    return DEPTH;
  endfunction

  function automatic int exp_pauses();
    int n = 0;
    for (int i = 0; i < exp_len() - 1; i++) if (m_pause[i]) n++;
    return n;
  endfunction

  task automatic chk_log(input string tag);
    chk({tag, " count"}, log_n, exp_len());
    for (int i = 0; i < exp_len() && i < log_n; i++) chk({tag, " chan"}, log_chan[i], m_chan[i]);
  endtask

  task automatic lat_to_req(output int c);
    c = 1;
    while (!conv_req && c < 200000) begin @(negedge clk); c++; end
  endtask

  initial begin
    int c;
    void'($urandom(32'd2024));
    rst_n = 1'b0; mode = 2'd0; edge_rise = 1'b1; qclk_en = 1'b1; ext_trig = 1'b0;
    arm = 1'b0; ovr_clr = 1'b0; ccw_we = 1'b0; ccw_addr = '0; ccw_wdata = '0;
    tmr_sel = 4'd0; spur_done = 1'b0; lat_fix = -1; sw_noise = 1'b0;
    log_n = 0; pause_cnt = 0; n_chk = 0; n_fail = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 armed", scan_armed, 0);
    chk("R1 req", conv_req, 0);
    chk("R1 paused", scan_paused, 0);
    chk("R1 overrun", trig_overrun, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 software start latency
    put(0, 6, 1'b0, 1'b1);
    for (int i = 1; i < DEPTH; i++) put(i, i, 1'b0, 1'b0);
    mode = 2'd0; log_n = 0;
    do_arm();
    lat_to_req(c);
    chk("R3 arm to req", c, 2);
    wait_idle();
    chk_log("R2 single word");

    // R2 R4 R5 R7: random software-mode queues with ext_trig noise
    for (int it = 0; it < 8; it++) begin
      for (int i = 0; i < DEPTH; i++)
        put(i, int'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0),
            (it > 1) && ($urandom_range(0, 5) == 0));
      log_n = 0; pause_cnt = 0; sw_noise = 1'b1;
      do_arm();
      wait_idle();
      sw_noise = 1'b0;
      repeat (3) @(negedge clk);
      chk_log("R2 order");
      chk("R4 pause cycles", pause_cnt, exp_pauses());
      chk("R5 no overrun", trig_overrun, 0);
      chk("R7 disarmed", scan_armed, 0);
      chk("R7 no req", conv_req, 0);
    end

    // R7 last address ends a queue with no end flag
    for (int i = 0; i < DEPTH; i++) put(i, 15 - i, 1'b0, 1'b0);
    log_n = 0;
    do_arm();
    wait_idle();
    repeat (5) @(negedge clk);
    chk("R7 last address count", log_n, DEPTH);
    chk_log("R7 full queue");

    // R12 spurious done and rearm
    @(negedge clk); spur_done = 1'b1;
    @(negedge clk); spur_done = 1'b0;
    @(negedge clk);
    chk("R12 stray done armed", scan_armed, 0);
    chk("R12 stray done req", conv_req, 0);
    fill_end();
    put(0, 3, 1'b0, 1'b0); put(1, 12, 1'b0, 1'b1);
    mode = 2'd1; edge_rise = 1'b1; ext_trig = 1'b0; log_n = 0;
    do_arm();
    repeat (4) @(negedge clk);
    do_arm();
    repeat (2) @(negedge clk);
    chk("R12 rearm still armed", scan_armed, 1);
    chk("R12 rearm no req", conv_req, 0);
    ext_trig = 1'b1;
    @(negedge clk);
    chk("R6 req one cycle after edge", conv_req, 1);
    wait_idle();
    repeat (3) @(negedge clk);
    chk_log("R12 after rearm");
    ext_trig = 1'b0;

    // R6 R9 falling polarity, edges ignored while disarmed
    put(0, 7, 1'b1, 1'b0); put(1, 9, 1'b0, 1'b0); put(2, 11, 1'b0, 1'b1);
    edge_rise = 1'b0; ext_trig = 1'b1; log_n = 0;
    repeat (2) @(negedge clk);
    ext_trig = 1'b0; repeat (3) @(negedge clk);
    ext_trig = 1'b1; repeat (3) @(negedge clk);
    chk("R6 disarmed edge armed", scan_armed, 0);
    chk("R6 disarmed edge count", log_n, 0);
    do_arm();
    repeat (3) @(negedge clk);
    chk("R6 waits for edge", conv_req, 0);
    ext_trig = 1'b0;
    @(negedge clk);
    chk("R6 falling edge starts", conv_req, 1);
    wait_paused();
    repeat (20) @(negedge clk);
    chk("R9 edge pause held", scan_paused, 1);
    ext_trig = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 wrong polarity ignored", scan_paused, 1);
    chk("R9 no req while paused", conv_req, 0);
    ext_trig = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk_log("R9 edge resume");
    chk("R10 no overrun in clean run", trig_overrun, 0);

    // R10 edge overrun during a long conversion
    put(0, 1, 1'b0, 1'b0); put(1, 2, 1'b0, 1'b1);
    edge_rise = 1'b1; ext_trig = 1'b0; lat_fix = 30; log_n = 0;
    do_arm();
    ext_trig = 1'b1;
    repeat (5) @(negedge clk);
    ext_trig = 1'b0; @(negedge clk);
    ext_trig = 1'b1; @(negedge clk);
    chk("R10 edge overrun set", trig_overrun, 1);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R10 overrun sticky", trig_overrun, 1);
    chk_log("R10 edge scan unchanged");
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk("R10 overrun cleared", trig_overrun, 0);
    ext_trig = 1'b0;

    // R8 R9 R11 interval timer
    put(0, 3, 1'b1, 1'b0); put(1, 5, 1'b0, 1'b1);
    mode = 2'd2; tmr_sel = 4'd0; lat_fix = 0; log_n = 0;
    do_arm();
    lat_to_req(c);
    chk("R8 period 128", c, 129);
    wait_paused();
    repeat (50) @(negedge clk);
    chk("R9 timer pause held", scan_paused, 1);
    chk("R9 timer pause no req", conv_req, 0);
    wait_idle();
    repeat (3) @(negedge clk);
    chk_log("R9 timer resume");
    repeat (37) @(negedge clk);
    log_n = 0;
    do_arm();
    lat_to_req(c);
    chk("R11 full period after rearm", c, 129);
    wait_idle();
    tmr_sel = 4'd1; log_n = 0;
    repeat (11) @(negedge clk);
    do_arm();
    lat_to_req(c);
    chk("R8 period 256", c, 257);
    wait_idle();

    // R10 timer overrun
    put(0, 4, 1'b0, 1'b1);
    tmr_sel = 4'd0; lat_fix = 200; log_n = 0;
    do_arm();
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R10 timer overrun set", trig_overrun, 1);
    chk("R10 timer scan unchanged", log_n, 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk("R10 timer overrun cleared", trig_overrun, 0);

    summary();
    $finish;
  end

endmodule